// File: doc/BRIEF.md
# Configuration Sequencing Controller

This controller steps a programmable device from power-up to normal operation. After power-up it runs a power-on timer whose length is set by mode pin 0, sampled once. It waits for an active-low reset input to be released, then latches the three mode pins and pulses a start strobe to the external bitstream loader. When the loader reports that it has finished, the controller enables the user outputs and releases the open-drain done line. The order of these two steps is set by a startup option.

The reset input means different things in different phases. Before configuration starts, it holds the start back. During configuration, it abandons the load and starts again once reset is released. After configuration, it only resets user storage, and it does so asynchronously. Once the device is running, an outside agent can pull the done line low to force a fresh configuration.

A power-down input puts the device into a quiet state while keeping its configuration. In that state user storage is held in reset, outputs are tri-stated and inputs read high. When power-down is released, the done line stays low for two timebase ticks before the device runs again. An internal divider derives the timebase tick from the controller clock.

Top module: `cfg_sequencer`

## Requirements
- R1: After the controller reset is released, mode pin 0 is sampled once on the first clock edge. The start strobe then appears on the clock edge that completes 2^SHORT_EXP timebase ticks if the pin was high, or 2^LONG_EXP ticks if it was low. One tick is TICK_DIV clocks, and the first tick ends on edge TICK_DIV.
- R2: If the reset input is still low when the power-on timer expires, the start strobe is withheld. It appears on the third clock edge after the reset input is released.
- R3: The start strobe is one clock cycle long. The mode output takes the value of the three mode pins at the strobe and keeps it until the next strobe.
- R4: If the reset input goes low during configuration, the load is abandoned and the status reads RESET_HOLD. A new start strobe follows within three clock edges after the reset input is released.
- R5: While the device is operational, a low reset input asserts the user-reset output at once, without waiting for a clock edge. Outputs stay enabled and no new configuration starts.
- R6: While the device is operational, a high-to-low transition on the done line causes a new start strobe within five clock edges. Outputs are disabled while the new configuration runs.
- R7: When the loader reports completion, the controller spends exactly one cycle in startup. With the early-done option set, the done line is released in that cycle and outputs are enabled in the next. With the option clear, outputs are enabled in that cycle and the done line is released in the next.
- R8: Once the device has powered down (status 6), outputs are disabled, user reset is asserted, the done line is driven low and inputs are forced high. The latched mode value is kept.
- R9: After power-down is released, the done line stays low and the device returns to operational between TICK_DIV+3 and 2*TICK_DIV+2 clock edges later.
- R10: The status output encodes the phase as follows: 0 power-on wait, 1 reset hold, 2 mode sample, 3 configuring, 4 startup, 5 operational, 6 powered down. While the controller reset is low it reads 0.
- R11: User reset is asserted in every phase except operational. The input-force-high output is asserted only while the device is powered down and power-down is still requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller reset, asynchronous, active low |
| pwr_down_n | input | 1 | Power-down request, active low |
| cfg_reset_n | input | 1 | Multi-purpose reset input, active low |
| mode_pins | input | 3 | Configuration mode pins |
| load_done | input | 1 | Completion indication from the bitstream loader |
| done_early | input | 1 | Startup option: release done before enabling outputs |
| done_in | input | 1 | Sensed level of the done line |
| cfg_start | output | 1 | One-cycle strobe that starts the loader |
| mode_latched | output | 3 | Mode value captured at the start strobe |
| user_reset | output | 1 | Global reset of user storage elements |
| out_enable | output | 1 | User output enable (low means tri-stated) |
| in_force_high | output | 1 | Forces user inputs to read high |
| done_drive_low | output | 1 | Open-drain pull-down of the done line |
| state_o | output | 3 | Status encoding of the current phase |

## Verification
The hardest cases to reach are the phase-dependent meanings of the reset input. The same low level must hold off the start, restart a load that is in progress, or only reset user logic. The bench reaches each case by timing the reset input against its own loader model: it asserts reset while the power-on timer is still running, between the start strobe and the loader's completion, and after startup has finished. It measures exact edge counts in each case. A second difficult case is a done-line fall after configuration, since the controller itself keeps that line low until startup. The bench drives an external pull-down onto the modelled open-drain line, which lets it reconfigure through all eight mode values in turn.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_POWER_WAIT = 3'd0,
    SEQ_RESET_HOLD = 3'd1,
    SEQ_SAMPLE     = 3'd2,
    SEQ_CONFIG     = 3'd3,
    SEQ_STARTUP    = 3'd4,
    SEQ_RUN        = 3'd5,
    SEQ_POWER_DOWN = 3'd6
  } seq_state_t;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned WAKE_TICKS = 2;
endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;
  logic [W-1:0] div_d;

  always_comb begin
    tick  = (div_q == LAST);
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cfg_sync_bus.sv
module cfg_sync_bus #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b1;
        stage2_q[i] <= 1'b1;
      end else begin
        stage1_q[i] <= async_in[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/cfg_seq_core.sv
module cfg_seq_core
  import cfg_seq_pkg::*;
#(
  parameter int unsigned SHORT_EXP = 14,
  parameter int unsigned LONG_EXP  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              reset_ok,
  input  logic              pd_ok,
  input  logic              done_fall,
  input  logic              load_done,
  output seq_state_t        state,
  output logic [MODE_W-1:0] mode_q
);
  localparam int unsigned MAXE = (LONG_EXP > SHORT_EXP) ? LONG_EXP : SHORT_EXP;
  localparam int unsigned CW = MAXE + 1;
  localparam logic [CW-1:0] SHORT_LAST = CW'((64'd1 << SHORT_EXP) - 64'd1);
  localparam logic [CW-1:0] LONG_LAST  = CW'((64'd1 << LONG_EXP) - 64'd1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_TICKS - 1);

  seq_state_t        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              sampled_q, sampled_d;
  logic              long_q, long_d;
  logic [MODE_W-1:0] mode_d;
  logic [CW-1:0]     po_last;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sampled_d = sampled_q;
    long_d    = long_q;
    mode_d    = mode_q;
    po_last   = long_q ? LONG_LAST : SHORT_LAST;
    unique case (state_q)
      SEQ_POWER_WAIT: begin
        if (!sampled_q) begin
          sampled_d = 1'b1;
          long_d    = ~mode_pins[0];
          cnt_d     = '0;
        end else if (tick) begin
          if (cnt_q == po_last) begin
            cnt_d   = '0;
            state_d = reset_ok ? SEQ_SAMPLE : SEQ_RESET_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_RESET_HOLD: begin
        if (reset_ok) state_d = SEQ_SAMPLE;
      end
      SEQ_SAMPLE: begin
        mode_d  = mode_pins;
        state_d = SEQ_CONFIG;
      end
      SEQ_CONFIG: begin
        if (!reset_ok)     state_d = SEQ_RESET_HOLD;
        else if (load_done) state_d = SEQ_STARTUP;
      end
      SEQ_STARTUP: state_d = SEQ_RUN;
      SEQ_RUN: begin
        if (!pd_ok) begin
          state_d = SEQ_POWER_DOWN;
          cnt_d   = '0;
        end else if (done_fall) begin
          state_d = SEQ_SAMPLE;
        end
      end
      SEQ_POWER_DOWN: begin
        if (!pd_ok) begin
          cnt_d = '0;
        end else if (tick) begin
          if (cnt_q == WAKE_LAST) begin
            cnt_d   = '0;
            state_d = SEQ_RUN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_POWER_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_POWER_WAIT;
      cnt_q     <= '0;
      sampled_q <= 1'b0;
      long_q    <= 1'b1;
      mode_q    <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sampled_q <= sampled_d;
      long_q    <= long_d;
      mode_q    <= mode_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cfg_seq_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 10,
  parameter int unsigned SHORT_EXP = 14,
  parameter int unsigned LONG_EXP  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down_n,
  input  logic       cfg_reset_n,
  input  logic [2:0] mode_pins,
  input  logic       load_done,
  input  logic       done_early,
  input  logic       done_in,
  output logic       cfg_start,
  output logic [2:0] mode_latched,
  output logic       user_reset,
  output logic       out_enable,
  output logic       in_force_high,
  output logic       done_drive_low,
  output logic [2:0] state_o
);
  logic       tick;
  logic [2:0] synced;
  logic       reset_ok, pd_ok, done_s;
  logic       done_prev_q;
  logic       done_fall;
  seq_state_t state;

  cfg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cfg_sync_bus #(.WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({done_in, pwr_down_n, cfg_reset_n}),
    .sync_out(synced)
  );

  assign reset_ok = synced[0];
  assign pd_ok    = synced[1];
  assign done_s   = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_prev_q <= 1'b1;
    else        done_prev_q <= done_s;
  end

  assign done_fall = done_prev_q & ~done_s;

  cfg_seq_core #(.SHORT_EXP(SHORT_EXP), .LONG_EXP(LONG_EXP)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_pins(mode_pins),
    .reset_ok(reset_ok), .pd_ok(pd_ok), .done_fall(done_fall),
    .load_done(load_done), .state(state), .mode_q(mode_latched)
  );

  always_comb begin
    cfg_start      = (state == SEQ_SAMPLE);
    out_enable     = (state == SEQ_RUN) || ((state == SEQ_STARTUP) && !done_early);
    done_drive_low = !((state == SEQ_RUN) || ((state == SEQ_STARTUP) && done_early));
    user_reset     = (state != SEQ_RUN) || !cfg_reset_n;
    in_force_high  = (state == SEQ_POWER_DOWN) && !pd_ok;
    state_o        = state;
  end
endmodule

// File: rtl/cfg_sequencer_chk.sv
module cfg_sequencer_chk
  import cfg_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_reset_n,
  input logic       done_early,
  input logic       cfg_start,
  input logic [2:0] mode_latched,
  input logic       user_reset,
  input logic       out_enable,
  input logic       in_force_high,
  input logic       done_drive_low,
  input logic [2:0] state_o
);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> !cfg_start);

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == SEQ_CONFIG && $past(state_o) == SEQ_CONFIG) |-> $stable(mode_latched));

  p_async_user_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == SEQ_RUN && !cfg_reset_n) |-> user_reset);

  p_late_done_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(done_drive_low) && !done_early && $past(state_o) == SEQ_STARTUP) |-> $past(out_enable));

  p_early_done_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_enable) && done_early && $past(state_o) == SEQ_STARTUP) |-> !$past(done_drive_low));

  p_quiet_power_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == SEQ_POWER_DOWN) |-> (!out_enable && done_drive_low && user_reset));

  p_force_high_scope_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_force_high |-> (state_o == SEQ_POWER_DOWN));
endmodule

bind cfg_sequencer cfg_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_reset_n(cfg_reset_n), .done_early(done_early),
  .cfg_start(cfg_start), .mode_latched(mode_latched), .user_reset(user_reset),
  .out_enable(out_enable), .in_force_high(in_force_high),
  .done_drive_low(done_drive_low), .state_o(state_o)
);

// File: tb/cfg_sequencer_test.sv
module cfg_sequencer_test;
  localparam int D  = 2;
  localparam int SE = 3;
  localparam int LE = 5;
  localparam int SHORT_EDGES = (1 << SE) * D;
  localparam int LONG_EDGES  = (1 << LE) * D;

  logic clk = 1'b0;
  logic rst_n, pwr_down_n, cfg_reset_n, load_done, done_early, ext_low;
  logic [2:0] mode_pins;
  logic cfg_start, user_reset, out_enable, in_force_high, done_drive_low;
  logic [2:0] mode_latched, state_o;
  logic done_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign done_in = ~(done_drive_low | ext_low);

  cfg_sequencer #(.TICK_DIV(D), .SHORT_EXP(SE), .LONG_EXP(LE)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_down_n(pwr_down_n), .cfg_reset_n(cfg_reset_n),
    .mode_pins(mode_pins), .load_done(load_done), .done_early(done_early),
    .done_in(done_in), .cfg_start(cfg_start), .mode_latched(mode_latched),
    .user_reset(user_reset), .out_enable(out_enable), .in_force_high(in_force_high),
    .done_drive_low(done_drive_low), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_up(input bit m0, input bit hold_reset);
    int e;
    bit seen;
    rst_n = 1'b0;
    cfg_reset_n = !hold_reset;
    mode_pins = {2'b00, m0};
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R10 reset status", state_o, 0);
    chk(!cfg_start && !out_enable && done_drive_low && user_reset, "R11 reset outputs",
        {cfg_start, out_enable, done_drive_low, user_reset}, 4'b0011);
    rst_n = 1'b1;
    e = 0;
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      e++;
      @(negedge clk);
      if (hold_reset && e == LONG_EDGES + 8) begin
        chk(state_o == 3'd1 && !seen, "R2 held in reset hold", state_o, 1);
        cfg_reset_n = 1'b1;
      end
      if (cfg_start) begin
        seen = 1;
        break;
      end
    end
    if (hold_reset)
      chk(seen && e == LONG_EDGES + 11, "R2 start after release", e, LONG_EDGES + 11);
    else
      chk(seen && e == (m0 ? SHORT_EDGES : LONG_EDGES), "R1 power-on delay", e,
          m0 ? SHORT_EDGES : LONG_EDGES);
    @(negedge clk);
    chk(!cfg_start, "R3 strobe one cycle", cfg_start, 0);
    chk(mode_latched == {2'b00, m0}, "R3 latched mode", mode_latched, {2'b00, m0});
  endtask

  task automatic finish_load(input bit early);
    logic s1_oe, s1_dl;
    done_early = early;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd3 && user_reset, "R11 configuring status", state_o, 3);
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
    s1_oe = out_enable;
    s1_dl = done_drive_low;
    chk(state_o == 3'd4, "R10 startup status", state_o, 4);
    if (early)
      chk(!s1_oe && !s1_dl, "R7 early startup cycle", {s1_oe, s1_dl}, 0);
    else
      chk(s1_oe && s1_dl, "R7 late startup cycle", {s1_oe, s1_dl}, 3);
    @(negedge clk);
    chk(out_enable && !done_drive_low && state_o == 3'd5 && !user_reset,
        "R7 operational", {out_enable, done_drive_low, state_o}, 5'b10101);
  endtask

  task automatic reconfig(input logic [2:0] m);
    bit seen = 0;
    mode_pins = m;
    ext_low = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cfg_start) begin
        seen = 1;
        break;
      end
    end
    ext_low = 1'b0;
    chk(seen, "R6 done fall restarts", seen, 1);
    @(negedge clk);
    chk(mode_latched == m, "R3 mode sweep", mode_latched, m);
    chk(!out_enable, "R6 outputs off in config", out_enable, 0);
  endtask

  initial begin
    rst_n = 1'b0; pwr_down_n = 1'b1; cfg_reset_n = 1'b1; load_done = 1'b0;
    done_early = 1'b0; ext_low = 1'b0; mode_pins = 3'b000;

    power_up(1'b1, 1'b0);
    finish_load(1'b1);
    power_up(1'b0, 1'b0);
    finish_load(1'b0);

    for (int m = 0; m < 8; m++) begin
      repeat (4) @(negedge clk);
      reconfig(3'(m));
      finish_load(m[0]);
    end

    // R5: reset after configuration only resets user storage
    @(negedge clk);
    cfg_reset_n = 1'b0;
    #1;
    chk(user_reset, "R5 immediate user reset", user_reset, 1);
    begin
      bit bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (cfg_start || !out_enable || state_o != 3'd5 || !user_reset) bad = 1;
      end
      chk(!bad, "R5 no restart", bad, 0);
    end
    cfg_reset_n = 1'b1;
    #1;
    chk(!user_reset, "R5 user reset released", user_reset, 0);

    // R4: reset during configuration
    repeat (4) @(negedge clk);
    reconfig(3'b101);
    cfg_reset_n = 1'b0;
    begin
      bit bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (cfg_start) bad = 1;
      end
      chk(!bad && state_o == 3'd1, "R4 load abandoned", state_o, 1);
    end
    mode_pins = 3'b010;
    cfg_reset_n = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (cfg_start) begin seen = 1; break; end
      end
      chk(seen, "R4 restart after release", seen, 1);
    end
    @(negedge clk);
    chk(mode_latched == 3'b010, "R4 new mode", mode_latched, 2);
    finish_load(1'b0);

    // R8/R9: power-down and wake
    mode_pins = 3'b111;
    @(negedge clk);
    pwr_down_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(state_o == 3'd6 && !out_enable && done_drive_low && user_reset && in_force_high,
        "R8 powered down", {state_o, out_enable, done_drive_low, user_reset, in_force_high},
        7'b1100111);
    chk(mode_latched == 3'b010, "R8 configuration kept", mode_latched, 2);
    pwr_down_n = 1'b1;
    begin
      int k = 0;
      for (int i = 1; i < 40; i++) begin
        @(negedge clk);
        if (!done_drive_low) begin k = i; break; end
      end
      chk(k >= D + 3 && k <= 2 * D + 2, "R9 wake delay", k, D + 3);
      chk(state_o == 3'd5 && out_enable && !in_force_high, "R9 operational again", state_o, 5);
    end

    // R2: reset held through power-on timer
    power_up(1'b0, 1'b1);
    finish_load(1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule